// File: doc/BRIEF.md
# Programmable System Address Decoder

This block sorts each physical address a host node sees into one of four results. The access either goes to local memory, goes to one of several PCI buses, is left unclaimed on the system bus, or is refused as a protected access. Several programmable windows shape the decode:

- a memory ceiling;
- two expansion holes that can each be switched on or off;
- a small legacy window below 16 MB that feeds the compatibility bus;
- a run of contiguous PCI ranges, one per bus;
- a protected system-management RAM window with a permission gate.

All window edges are whole 1 MB pages. Comparisons use address bits [ADDR_W-1:20], with the lower edge inclusive and the upper edge exclusive.

Settings are presented on `cfg_*` inputs and take effect only when `cfg_load` captures them into internal registers. Reset disables every window and places the ceiling at the last page. Each request yields one registered result one cycle later. When a result is "unclaimed", an orphan timer starts. If no other agent raises `ext_claim` before the programmed limit runs out, the block emits a one-cycle `term_pulse` to claim and end the access itself.

Top module: `sys_addr_decoder`

## Requirements
- R1: After reset, `dec_valid` and `term_pulse` are 0. Before any `cfg_load`, every page below 0xFFFF decodes as memory, and page 0xFFFF decodes as unclaimed.
- R2: `dec_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise. Result kind codes are: memory = 0, PCI = 1, unclaimed = 2, denied = 3. `dec_bus` is 0 unless the kind is PCI.
- R3: A page at or above the loaded ceiling decodes as unclaimed, unless it is denied by R8.
- R4: A page inside an enabled expansion hole (low or high, base inclusive, top exclusive) never decodes as memory. It decodes as PCI if a PCI range matches, otherwise as unclaimed.
- R5: While a hole is disabled, its pages decode as memory when nothing else matches.
- R6: PCI range k covers pages from the previous boundary (the PCI base for k = 0) up to boundary k, exclusive. A hit decodes as PCI with `dec_bus` = k.
- R7: The legacy window covers pages [start, start + 2^size), where start is 0..15 MB and the size code is 0..3. A hit decodes as PCI bus 0 and takes precedence over the PCI ranges.
- R8: A page inside the enabled protected window decodes as memory only when `cfg_smram_open` was loaded as 1 and `req_priv` is 1. Otherwise it decodes as denied, and this takes precedence over every other rule.
- R9: Changing `cfg_*` inputs without `cfg_load` has no effect on the decode.
- R10: When an unclaimed result is shown in cycle T, and no claim is seen in cycles T+1..T+L (L = loaded limit, with 0 treated as 1), `term_pulse` is high for exactly cycle T+L+1.
- R11: `ext_claim` seen while the timer runs cancels the pending pulse.
- R12: A new unclaimed result restarts the timer from the full limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | request strobe |
| req_addr | input | ADDR_W | physical address |
| req_priv | input | 1 | requester is in privileged mode |
| cfg_load | input | 1 | capture all cfg_* inputs |
| cfg_tom | input | PW | memory ceiling page |
| cfg_lgap_en | input | 1 | low hole enable |
| cfg_lgap_base | input | PW | low hole first page |
| cfg_lgap_top | input | PW | low hole end page (exclusive) |
| cfg_hgap_en | input | 1 | high hole enable |
| cfg_hgap_base | input | PW | high hole first page |
| cfg_hgap_top | input | PW | high hole end page (exclusive) |
| cfg_isa_en | input | 1 | legacy window enable |
| cfg_isa_start | input | 4 | legacy window first MB |
| cfg_isa_size | input | 2 | legacy window size code (2^code MB) |
| cfg_pci_base | input | PW | first page of PCI range 0 |
| cfg_pci_tops | input | NUM_PCI*PW | end page of each PCI range, range k in slice k |
| cfg_smram_en | input | 1 | protected window enable |
| cfg_smram_open | input | 1 | protected access permitted |
| cfg_smram_base | input | PW | protected window first page |
| cfg_smram_top | input | PW | protected window end page (exclusive) |
| cfg_timeout | input | TMR_W | orphan timer limit in cycles |
| ext_claim | input | 1 | another agent claimed the access |
| dec_valid | output | 1 | result valid |
| dec_kind | output | 2 | result kind |
| dec_bus | output | BUS_W | PCI bus index |
| term_pulse | output | 1 | self-claim and terminate strobe |

## Verification
The decode is driven with one configuration that has every window enabled. Addresses are picked on both sides of each edge: hole base and top, PCI boundaries, the legacy window end, and the ceiling. These pages separate inclusive from exclusive comparisons and show which rule wins where windows overlap.

The configuration is then reloaded with holes disabled and with the protected window closed. Inputs are also changed without a load. These runs tell apart a hole that is really gated, a permission that is really checked, and configuration that is really registered.

The timer is run three ways: left alone, claimed in mid-count, and restarted by a second orphan. Each run tells apart the pulse cycle, cancellation and reload.

// File: rtl/adec_pkg.sv
package adec_pkg;

   typedef enum logic [1:0] {
      RK_MEM  = 2'd0,
      RK_PCI  = 2'd1,
      RK_UNCL = 2'd2,
      RK_DENY = 2'd3
   } route_kind_e;

   // legacy window span in MB from its two-bit size code
   function automatic logic [4:0] legacy_span_mb(input logic [1:0] code);
      return 5'd1 << code;
   endfunction

endpackage

// File: rtl/adec_cfg_regs.sv
module adec_cfg_regs #(
   parameter int PW      = 16,
   parameter int NUM_PCI = 4,
   parameter int TMR_W   = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_load,
   input  logic [PW-1:0]         in_tom,
   input  logic                  in_lgap_en,
   input  logic [PW-1:0]         in_lgap_base,
   input  logic [PW-1:0]         in_lgap_top,
   input  logic                  in_hgap_en,
   input  logic [PW-1:0]         in_hgap_base,
   input  logic [PW-1:0]         in_hgap_top,
   input  logic                  in_isa_en,
   input  logic [3:0]            in_isa_start,
   input  logic [1:0]            in_isa_size,
   input  logic [PW-1:0]         in_pci_base,
   input  logic [NUM_PCI*PW-1:0] in_pci_tops,
   input  logic                  in_sm_en,
   input  logic                  in_sm_open,
   input  logic [PW-1:0]         in_sm_base,
   input  logic [PW-1:0]         in_sm_top,
   input  logic [TMR_W-1:0]      in_timeout,
   output logic [PW-1:0]         tom_q,
   output logic                  lgap_en_q,
   output logic [PW-1:0]         lgap_base_q,
   output logic [PW-1:0]         lgap_top_q,
   output logic                  hgap_en_q,
   output logic [PW-1:0]         hgap_base_q,
   output logic [PW-1:0]         hgap_top_q,
   output logic                  isa_en_q,
   output logic [3:0]            isa_start_q,
   output logic [1:0]            isa_size_q,
   output logic [PW-1:0]         pci_base_q,
   output logic [NUM_PCI*PW-1:0] pci_tops_q,
   output logic                  sm_en_q,
   output logic                  sm_open_q,
   output logic [PW-1:0]         sm_base_q,
   output logic [PW-1:0]         sm_top_q,
   output logic [TMR_W-1:0]      timeout_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tom_q       <= '1;
         lgap_en_q   <= 1'b0;
         lgap_base_q <= '0;
         lgap_top_q  <= '0;
         hgap_en_q   <= 1'b0;
         hgap_base_q <= '0;
         hgap_top_q  <= '0;
         isa_en_q    <= 1'b0;
         isa_start_q <= '0;
         isa_size_q  <= '0;
         pci_base_q  <= '0;
         pci_tops_q  <= '0;
         sm_en_q     <= 1'b0;
         sm_open_q   <= 1'b0;
         sm_base_q   <= '0;
         sm_top_q    <= '0;
         timeout_q   <= '0;
      end else if (cfg_load) begin
         tom_q       <= in_tom;
         lgap_en_q   <= in_lgap_en;
         lgap_base_q <= in_lgap_base;
         lgap_top_q  <= in_lgap_top;
         hgap_en_q   <= in_hgap_en;
         hgap_base_q <= in_hgap_base;
         hgap_top_q  <= in_hgap_top;
         isa_en_q    <= in_isa_en;
         isa_start_q <= in_isa_start;
         isa_size_q  <= in_isa_size;
         pci_base_q  <= in_pci_base;
         pci_tops_q  <= in_pci_tops;
         sm_en_q     <= in_sm_en;
         sm_open_q   <= in_sm_open;
         sm_base_q   <= in_sm_base;
         sm_top_q    <= in_sm_top;
         timeout_q   <= in_timeout;
      end
   end

   // R9: configuration moves only on a load
   a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> ($stable(tom_q) && $stable(lgap_en_q) && $stable(hgap_en_q)
                     && $stable(sm_open_q) && $stable(timeout_q)));

endmodule

// File: rtl/adec_classify.sv
module adec_classify
   import adec_pkg::*;
#(
   parameter int PW      = 16,
   parameter int NUM_PCI = 4,
   parameter int BUS_W   = 2
) (
   input  logic [PW-1:0]         page,
   input  logic                  priv,
   input  logic [PW-1:0]         tom,
   input  logic                  lgap_en,
   input  logic [PW-1:0]         lgap_base,
   input  logic [PW-1:0]         lgap_top,
   input  logic                  hgap_en,
   input  logic [PW-1:0]         hgap_base,
   input  logic [PW-1:0]         hgap_top,
   input  logic                  isa_en,
   input  logic [3:0]            isa_start,
   input  logic [1:0]            isa_size,
   input  logic [PW-1:0]         pci_base,
   input  logic [NUM_PCI*PW-1:0] pci_tops,
   input  logic                  sm_en,
   input  logic                  sm_open,
   input  logic [PW-1:0]         sm_base,
   input  logic [PW-1:0]         sm_top,
   output route_kind_e           kind,
   output logic [BUS_W-1:0]      bus
);

   logic [PW-1:0]      isa_lo, isa_hi;
   logic               isa_hit, sm_hit, below_tom, lgap_hit, hgap_hit;
   logic [NUM_PCI-1:0] pci_hit;
   logic               pci_any;
   logic [BUS_W-1:0]   pci_idx;

   assign isa_lo    = PW'(isa_start);
   assign isa_hi    = isa_lo + PW'(legacy_span_mb(isa_size));
   assign isa_hit   = isa_en && (page >= isa_lo) && (page < isa_hi);
   assign sm_hit    = sm_en && (page >= sm_base) && (page < sm_top);
   assign below_tom = page < tom;
   assign lgap_hit  = lgap_en && (page >= lgap_base) && (page < lgap_top);
   assign hgap_hit  = hgap_en && (page >= hgap_base) && (page < hgap_top);

   // one comparator pair per PCI range, each range starting where the last ends
   for (genvar k = 0; k < NUM_PCI; k++) begin : g_rng
      logic [PW-1:0] lo;
      logic [PW-1:0] hi;
      if (k == 0) begin : g_first
         assign lo = pci_base;
      end else begin : g_next
         assign lo = pci_tops[(k-1)*PW +: PW];
      end
      assign hi         = pci_tops[k*PW +: PW];
      assign pci_hit[k] = (page >= lo) && (page < hi);
   end

   always_comb begin
      pci_any = 1'b0;
      pci_idx = '0;
      for (int k = NUM_PCI - 1; k >= 0; k--) begin
         if (pci_hit[k]) begin
            pci_any = 1'b1;
            pci_idx = BUS_W'(k);
         end
      end
   end

   // fixed priority: protected window, ceiling, legacy, PCI, holes, memory
   always_comb begin
      kind = RK_MEM;
      bus  = '0;
      if (sm_hit && !(sm_open && priv)) begin
         kind = RK_DENY;
      end else if (!below_tom) begin
         kind = RK_UNCL;
      end else if (sm_hit) begin
         kind = RK_MEM;
      end else if (isa_hit) begin
         kind = RK_PCI;
      end else if (pci_any) begin
         kind = RK_PCI;
         bus  = pci_idx;
      end else if (lgap_hit || hgap_hit) begin
         kind = RK_UNCL;
      end
   end

endmodule

// File: rtl/adec_orphan_timer.sv
module adec_orphan_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [TMR_W-1:0] limit,
   input  logic             ext_claim,
   output logic             term_pulse
);

   logic             busy;
   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         cnt        <= '0;
         term_pulse <= 1'b0;
      end else begin
         term_pulse <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            cnt  <= (limit == '0) ? TMR_W'(1) : limit;
         end else if (busy) begin
            if (ext_claim) begin
               busy <= 1'b0;
            end else if (cnt == TMR_W'(1)) begin
               busy       <= 1'b0;
               term_pulse <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R10: pulse lasts one cycle
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      term_pulse |=> !term_pulse);

   // R11: a claim stops the countdown without a pulse
   a_r11_claim_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ext_claim && !start) |=> (!busy && !term_pulse));

   // R12: a restart always leaves the timer counting
   a_r12_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !term_pulse));

endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
   import adec_pkg::*;
#(
   parameter int ADDR_W   = 36,
   parameter int PAGE_LSB = 20,
   parameter int NUM_PCI  = 4,
   parameter int TMR_W    = 16,
   localparam int PW      = ADDR_W - PAGE_LSB,
   localparam int BUS_W   = (NUM_PCI > 1) ? $clog2(NUM_PCI) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic                  req_priv,
   input  logic                  cfg_load,
   input  logic [PW-1:0]         cfg_tom,
   input  logic                  cfg_lgap_en,
   input  logic [PW-1:0]         cfg_lgap_base,
   input  logic [PW-1:0]         cfg_lgap_top,
   input  logic                  cfg_hgap_en,
   input  logic [PW-1:0]         cfg_hgap_base,
   input  logic [PW-1:0]         cfg_hgap_top,
   input  logic                  cfg_isa_en,
   input  logic [3:0]            cfg_isa_start,
   input  logic [1:0]            cfg_isa_size,
   input  logic [PW-1:0]         cfg_pci_base,
   input  logic [NUM_PCI*PW-1:0] cfg_pci_tops,
   input  logic                  cfg_smram_en,
   input  logic                  cfg_smram_open,
   input  logic [PW-1:0]         cfg_smram_base,
   input  logic [PW-1:0]         cfg_smram_top,
   input  logic [TMR_W-1:0]      cfg_timeout,
   input  logic                  ext_claim,
   output logic                  dec_valid,
   output logic [1:0]            dec_kind,
   output logic [BUS_W-1:0]      dec_bus,
   output logic                  term_pulse
);

   if (PW < 5) begin : g_bad_width
      $error("address must keep at least 5 page bits above PAGE_LSB");
   end
   if (NUM_PCI < 1 || NUM_PCI > 16) begin : g_bad_pci
      $error("NUM_PCI must be 1..16");
   end
   if (TMR_W < 2) begin : g_bad_tmr
      $error("TMR_W must be at least 2");
   end

   logic [PW-1:0]         tom_q, lgap_base_q, lgap_top_q, hgap_base_q, hgap_top_q;
   logic [PW-1:0]         pci_base_q, sm_base_q, sm_top_q;
   logic [NUM_PCI*PW-1:0] pci_tops_q;
   logic                  lgap_en_q, hgap_en_q, isa_en_q, sm_en_q, sm_open_q;
   logic [3:0]            isa_start_q;
   logic [1:0]            isa_size_q;
   logic [TMR_W-1:0]      timeout_q;
   logic [PW-1:0]         page;
   route_kind_e           nxt_kind;
   logic [BUS_W-1:0]      nxt_bus;
   logic                  orphan_start;

   assign page = req_addr[ADDR_W-1:PAGE_LSB];

   adec_cfg_regs #(.PW(PW), .NUM_PCI(NUM_PCI), .TMR_W(TMR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .in_tom(cfg_tom),
      .in_lgap_en(cfg_lgap_en), .in_lgap_base(cfg_lgap_base), .in_lgap_top(cfg_lgap_top),
      .in_hgap_en(cfg_hgap_en), .in_hgap_base(cfg_hgap_base), .in_hgap_top(cfg_hgap_top),
      .in_isa_en(cfg_isa_en), .in_isa_start(cfg_isa_start), .in_isa_size(cfg_isa_size),
      .in_pci_base(cfg_pci_base), .in_pci_tops(cfg_pci_tops),
      .in_sm_en(cfg_smram_en), .in_sm_open(cfg_smram_open),
      .in_sm_base(cfg_smram_base), .in_sm_top(cfg_smram_top),
      .in_timeout(cfg_timeout),
      .tom_q(tom_q),
      .lgap_en_q(lgap_en_q), .lgap_base_q(lgap_base_q), .lgap_top_q(lgap_top_q),
      .hgap_en_q(hgap_en_q), .hgap_base_q(hgap_base_q), .hgap_top_q(hgap_top_q),
      .isa_en_q(isa_en_q), .isa_start_q(isa_start_q), .isa_size_q(isa_size_q),
      .pci_base_q(pci_base_q), .pci_tops_q(pci_tops_q),
      .sm_en_q(sm_en_q), .sm_open_q(sm_open_q), .sm_base_q(sm_base_q), .sm_top_q(sm_top_q),
      .timeout_q(timeout_q)
   );

   adec_classify #(.PW(PW), .NUM_PCI(NUM_PCI), .BUS_W(BUS_W)) u_cls (
      .page(page), .priv(req_priv), .tom(tom_q),
      .lgap_en(lgap_en_q), .lgap_base(lgap_base_q), .lgap_top(lgap_top_q),
      .hgap_en(hgap_en_q), .hgap_base(hgap_base_q), .hgap_top(hgap_top_q),
      .isa_en(isa_en_q), .isa_start(isa_start_q), .isa_size(isa_size_q),
      .pci_base(pci_base_q), .pci_tops(pci_tops_q),
      .sm_en(sm_en_q), .sm_open(sm_open_q), .sm_base(sm_base_q), .sm_top(sm_top_q),
      .kind(nxt_kind), .bus(nxt_bus)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_kind  <= 2'd0;
         dec_bus   <= '0;
      end else begin
         dec_valid <= req_valid;
         if (req_valid) begin
            dec_kind <= nxt_kind;
            dec_bus  <= nxt_bus;
         end
      end
   end

   assign orphan_start = dec_valid && (dec_kind == RK_UNCL);

   adec_orphan_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(orphan_start), .limit(timeout_q),
      .ext_claim(ext_claim), .term_pulse(term_pulse)
   );

   // R2: one result per request, one cycle later
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid);
   // R3: nothing at or above the ceiling reaches memory or a PCI bus
   a_r3_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && page >= tom_q) |=> (dec_kind == RK_UNCL || dec_kind == RK_DENY));
   // R4: an enabled hole never yields memory
   a_r4_hole_not_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && lgap_en_q && page >= lgap_base_q && page < lgap_top_q)
      |=> (dec_kind != RK_MEM));
   // R8: a denial implies the permission check failed
   a_r8_deny_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_kind == RK_DENY) |-> !($past(req_priv) && $past(sm_open_q)));

endmodule

// File: tb/sys_addr_decoder_test.sv
module sys_addr_decoder_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 36;
   localparam int PW = 16;
   localparam int NP = 4;
   localparam int TW = 16;
   localparam int BW = 2;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_priv = 0, cfg_load = 0, ext_claim = 0;
   logic [AW-1:0] req_addr = '0;
   logic [PW-1:0] cfg_tom = '0, cfg_lgap_base = '0, cfg_lgap_top = '0;
   logic [PW-1:0] cfg_hgap_base = '0, cfg_hgap_top = '0, cfg_pci_base = '0;
   logic [PW-1:0] cfg_smram_base = '0, cfg_smram_top = '0;
   logic cfg_lgap_en = 0, cfg_hgap_en = 0, cfg_isa_en = 0, cfg_smram_en = 0, cfg_smram_open = 0;
   logic [3:0] cfg_isa_start = '0;
   logic [1:0] cfg_isa_size = '0;
   logic [NP*PW-1:0] cfg_pci_tops = '0;
   logic [TW-1:0] cfg_timeout = '0;
   logic dec_valid, term_pulse;
   logic [1:0] dec_kind;
   logic [BW-1:0] dec_bus;

   int checks = 0, fails = 0;
   bit done = 0;

   typedef struct { logic [1:0] kind; logic [BW-1:0] bus; string tag; } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sys_addr_decoder uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_priv(req_priv),
      .cfg_load(cfg_load), .cfg_tom(cfg_tom),
      .cfg_lgap_en(cfg_lgap_en), .cfg_lgap_base(cfg_lgap_base), .cfg_lgap_top(cfg_lgap_top),
      .cfg_hgap_en(cfg_hgap_en), .cfg_hgap_base(cfg_hgap_base), .cfg_hgap_top(cfg_hgap_top),
      .cfg_isa_en(cfg_isa_en), .cfg_isa_start(cfg_isa_start), .cfg_isa_size(cfg_isa_size),
      .cfg_pci_base(cfg_pci_base), .cfg_pci_tops(cfg_pci_tops),
      .cfg_smram_en(cfg_smram_en), .cfg_smram_open(cfg_smram_open),
      .cfg_smram_base(cfg_smram_base), .cfg_smram_top(cfg_smram_top),
      .cfg_timeout(cfg_timeout), .ext_claim(ext_claim),
      .dec_valid(dec_valid), .dec_kind(dec_kind), .dec_bus(dec_bus), .term_pulse(term_pulse)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver: one request, expected result queued for the monitor
   task automatic send(input logic [PW-1:0] pg, input logic priv, input logic [1:0] kind,
                       input logic [BW-1:0] bus, input string tag);
      exp_t e;
      e.kind = kind; e.bus = bus; e.tag = tag;
      @(negedge clk);
      sb.push_back(e);
      req_valid = 1; req_addr = {pg, 20'h0}; req_priv = priv;
      @(negedge clk);
      req_valid = 0; req_priv = 0;
   endtask

   // monitor: compare every result against the head of the queue
   always @(negedge clk) begin
      if (rst_n && dec_valid) begin
         if (sb.size() == 0) begin
            check(0, "R2 unexpected result", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(dec_kind == e.kind, {e.tag, " kind"}, dec_kind, e.kind);
            check(dec_bus == e.bus, {e.tag, " bus"}, dec_bus, e.bus);
         end
      end
   end

   task automatic load_cfg();
      @(negedge clk); cfg_load = 1;
      @(negedge clk); cfg_load = 0;
   endtask

   // wait out the timer from cycle T; expect pulse at T+exp_at (0 = none)
   task automatic watch_term(input int span, input int exp_at, input int claim_at, input string tag);
      for (int i = 1; i <= span; i++) begin
         if (i == claim_at) ext_claim = 1;
         @(negedge clk);
         ext_claim = 0;
         check(term_pulse == (i == exp_at), tag, term_pulse, (i == exp_at));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      checks++; fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(dec_valid == 0, "R1 valid in reset", dec_valid, 0);
      rst_n = 1;
      @(negedge clk);
      check(dec_valid == 0 && term_pulse == 0, "R1 idle after reset", dec_valid, 0);
      send(16'h0044, 0, 2'd0, 0, "R1 pre-load memory");
      send(16'h0091, 0, 2'd0, 0, "R1 pre-load memory hi");
      send(16'hFFFF, 0, 2'd2, 0, "R1 last page unclaimed");

      cfg_tom = 16'h0100;
      cfg_lgap_en = 1; cfg_lgap_base = 16'h0040; cfg_lgap_top = 16'h0060;
      cfg_hgap_en = 1; cfg_hgap_base = 16'h0080; cfg_hgap_top = 16'h00A0;
      cfg_isa_en = 1; cfg_isa_start = 4'd2; cfg_isa_size = 2'd1;
      cfg_pci_base = 16'h0050;
      cfg_pci_tops = {16'h0098, 16'h0090, 16'h005C, 16'h0058};
      cfg_smram_en = 1; cfg_smram_open = 1; cfg_smram_base = 16'h000A; cfg_smram_top = 16'h000C;
      cfg_timeout = 16'd5;
      load_cfg();

      send(16'h0001, 0, 2'd0, 0, "R5 plain memory");
      send(16'h0002, 0, 2'd1, 0, "R7 legacy first page");
      send(16'h0003, 0, 2'd1, 0, "R7 legacy last page");
      send(16'h0004, 0, 2'd0, 0, "R7 legacy end exclusive");
      send(16'h000A, 1, 2'd0, 0, "R8 privileged permitted");
      send(16'h000B, 0, 2'd3, 0, "R8 unprivileged denied");
      send(16'h0040, 0, 2'd2, 0, "R4 low hole base");
      send(16'h0052, 0, 2'd1, 0, "R6 bus0 in hole");
      send(16'h0059, 0, 2'd1, 1, "R6 bus1");
      send(16'h005C, 0, 2'd1, 2, "R6 bus2 lower edge");
      send(16'h008F, 0, 2'd1, 2, "R6 bus2 upper page");
      send(16'h0090, 0, 2'd1, 3, "R6 bus3");
      send(16'h009C, 0, 2'd2, 0, "R4 high hole no PCI");
      send(16'h00A0, 0, 2'd0, 0, "R4 hole top exclusive");
      send(16'h00FF, 0, 2'd0, 0, "R3 page below ceiling");
      send(16'h0100, 0, 2'd2, 0, "R3 ceiling page");
      send(16'h0200, 1, 2'd2, 0, "R3 far above ceiling");

      cfg_smram_open = 0; cfg_smram_base = 16'h0100; cfg_smram_top = 16'h0102;
      load_cfg();
      send(16'h0100, 1, 2'd3, 0, "R8 closed deny above ceiling");
      send(16'h000A, 1, 2'd0, 0, "R8 window moved");

      cfg_lgap_en = 0; cfg_hgap_en = 0;
      load_cfg();
      send(16'h0044, 0, 2'd0, 0, "R5 low hole off");
      send(16'h009C, 0, 2'd0, 0, "R5 high hole off");

      cfg_lgap_en = 1; cfg_tom = 16'h0010;
      @(negedge clk);
      send(16'h0044, 0, 2'd0, 0, "R9 unloaded change ignored");

      repeat (10) @(negedge clk);
      send(16'h0300, 0, 2'd2, 0, "R10 orphan");
      watch_term(8, 6, 0, "R10 pulse timing");
      send(16'h0300, 0, 2'd2, 0, "R11 orphan");
      watch_term(8, 0, 3, "R11 claim cancels");
      send(16'h0300, 0, 2'd2, 0, "R12 first orphan");
      @(negedge clk);
      send(16'h0300, 0, 2'd2, 0, "R12 second orphan");
      watch_term(8, 6, 0, "R12 restart timing");

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R2 results outstanding", sb.size(), 0);
      finish_run();
   end
endmodule